// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is a timer for one processor, reached through four 32-bit word registers. A mode input from the system controller selects one of two meanings for the same register window. In counter mode the block counts up to a programmable limit, sets a reached flag and raises its interrupt when the count gets there, then starts over. In user-timer mode the same storage becomes a 64-bit counter. Software loads it as two halves, starts and stops it, and it never interrupts.

Time comes from a tick-enable input that an external prescaler drives. Each tick adds one step of 512 to the visible count. The low nine bits of every count value therefore read as zero. The register bus is a plain single-cycle strobe interface that takes a word index. Read data is registered and appears one clock after the read strobe.

Top module: `proc_timer`

## Requirements
- R1: After reset the limit, count, reached flag and interrupt are all zero and the timer is running: a status read returns 1, and counter and limit reads return 0.
- R2: The word index selects the register: 0 = limit (counter mode) or high half (user mode), 1 = counter or low half, 2 = limit-without-restart, 3 = status. Read data appears on the clock after the read strobe. Index 2 reads as 0.
- R3: In counter mode each tick adds 512 to the count. A counter read returns the reached flag in bit 31, the count in bits 30:9 and zero in bits 8:0.
- R4: In counter mode the limit is bits 30:9 of the written word; the other bits are dropped. On the tick that makes the count equal to the limit, the reached flag and the interrupt go high. The next tick returns the count to 0, and counting continues. A limit of 0 means counting runs to 0x7FFFFE00.
- R5: In counter mode a write to index 0 stores the limit, clears the count and lowers the interrupt. A write to index 2 stores the limit and leaves the count as it was.
- R6: In counter mode a read of index 0 returns the limit in bits 30:9 and clears the reached flag and the interrupt. If a tick reaches the limit in the same cycle, the flag and the interrupt stay set.
- R7: In counter mode a write to index 1 has no effect on the count.
- R8: In user mode a write to index 0 loads count bits 62:32 from data bits 30:0. A write to index 1 loads count bits 31:9 from data bits 31:9. Either write clears the reached flag. A read of index 0 returns {reached, count[62:32]}, and a read of index 1 returns count[31:0]. A carry passes from the low half into the high half.
- R9: In user mode bit 0 of a status write starts the count (1) or stops it (0). A stopped count ignores ticks. A status read returns the running state in bit 0.
- R10: In user mode the interrupt stays low. The reached flag goes high on the tick that brings the count to its maximum, 0x7FFFFFFF_FFFFFE00, and the next tick wraps the count to 0.
- R11: Entering user mode stops the count and clears the count, the reached flag and the interrupt. Leaving user mode clears the count and the reached flag, sets the timer running and keeps the stored limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_widx | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| user_mode | input | 1 | 1 selects user-timer mode, 0 selects counter mode |
| tick | input | 1 | Count enable, one step per asserted cycle |
| irq | output | 1 | Limit interrupt, registered |

## Verification
The assertions assume that the mode input changes only in a cycle with no bus access, and that read and write strobes never occur together. They also assume that a mode change is followed by at least one quiet cycle before the window is used. The bench drives every input at the falling edge and changes the mode only during idle gaps. It issues strobes one at a time, so a register access never coincides with a mode change. Ticks are kept apart from bus accesses in the sweeps, so each expected count follows from simple arithmetic on the tick total.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    IDX_LIMIT = 2'd0,
    IDX_COUNT = 2'd1,
    IDX_LIMNR = 2'd2,
    IDX_STAT  = 2'd3
  } tmr_idx_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int NREG  = 4,
  parameter int IDX_W = 2
) (
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] bus_widx,
  input  logic             user_mode,
  output logic [NREG-1:0]  wr_vec,
  output logic             rd_lim
);
  import tmr_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_wstb
    assign wr_vec[g] = bus_wr && (bus_widx == IDX_W'(g));
  end

  // the read side effect exists only in counter mode
  assign rd_lim = bus_rd && !user_mode && (bus_widx == IDX_W'(IDX_LIMIT));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int WORD_W = 32,
  parameter int SHIFT  = 9,
  localparam int LO_W  = WORD_W - 1 - SHIFT,
  localparam int UL_W  = WORD_W - SHIFT,
  localparam int HI_W  = WORD_W - 1,
  localparam int TW    = UL_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              user_mode,
  input  logic              tick,
  input  logic              wr_lim,
  input  logic              wr_cnt,
  input  logic              wr_nrs,
  input  logic              wr_sts,
  input  logic              rd_lim,
  input  logic [WORD_W-1:0] wdata,
  output logic [TW-1:0]     ticks_o,
  output logic [LO_W-1:0]   lim_o,
  output logic              reached_o,
  output logic              running_o,
  output logic              irq_o
);
  logic [TW-1:0]   ticks;
  logic [LO_W-1:0] lim;
  logic            reached, running, irq_q, mode_q;
  logic [LO_W-1:0] cnt_lo, eff_lim;
  logic            lim_hit, lim_arrive;
  logic [TW-1:0]   ticks_inc;

  assign cnt_lo     = ticks[LO_W-1:0];
  assign eff_lim    = (lim == '0) ? '1 : lim;
  assign lim_hit    = (cnt_lo == eff_lim);
  assign lim_arrive = ((cnt_lo + LO_W'(1)) == eff_lim);
  assign ticks_inc  = ticks + TW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks   <= '0;
      lim     <= '0;
      reached <= 1'b0;
      irq_q   <= 1'b0;
      running <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= user_mode;
      if (user_mode && !mode_q) begin
        running <= 1'b0;
        ticks   <= '0;
        reached <= 1'b0;
        irq_q   <= 1'b0;
      end else if (!user_mode && mode_q) begin
        running <= 1'b1;
        ticks   <= '0;
        reached <= 1'b0;
        irq_q   <= 1'b0;
      end else if (user_mode) begin
        if (wr_lim) begin
          ticks   <= {wdata[HI_W-1:0], ticks[UL_W-1:0]};
          reached <= 1'b0;
        end else if (wr_cnt) begin
          ticks   <= {ticks[TW-1:UL_W], wdata[WORD_W-1:SHIFT]};
          reached <= 1'b0;
        end else if (running && tick) begin
          ticks <= ticks_inc;
          if (ticks_inc == '1) reached <= 1'b1;
        end
        if (wr_sts) running <= wdata[0];
        if (wr_nrs) lim <= wdata[WORD_W-2:SHIFT];
      end else begin
        if (rd_lim) begin
          reached <= 1'b0;
          irq_q   <= 1'b0;
        end
        if (wr_nrs) lim <= wdata[WORD_W-2:SHIFT];
        if (wr_lim) begin
          lim   <= wdata[WORD_W-2:SHIFT];
          ticks <= '0;
          irq_q <= 1'b0;
        end else if (tick) begin
          ticks <= lim_hit ? '0 : ticks_inc;
          if (lim_arrive) begin
            reached <= 1'b1;
            irq_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign ticks_o   = ticks;
  assign lim_o     = lim;
  assign reached_o = reached;
  assign running_o = running;
  assign irq_o     = irq_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && !mode_q && tick && !wr_lim && !lim_hit) |=> ticks == $past(ticks) + TW'(1)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && !mode_q && tick && !wr_lim && lim_hit) |=> ticks == '0); // R4
  AST_LIMIT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && !mode_q && wr_lim) |=> (ticks == '0 && !irq_q)); // R5
  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> reached); // R6
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (user_mode && mode_q && !running && !wr_lim && !wr_cnt) |=> $stable(ticks)); // R9
  AST_USER_SILENT: assert property (@(posedge clk) disable iff (rst)
    (user_mode && mode_q) |-> !irq_q); // R10
  AST_ENTRY_STOP: assert property (@(posedge clk) disable iff (rst)
    (user_mode && !mode_q) |=> (!running && ticks == '0 && !reached)); // R11
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int WORD_W = 32,
  parameter int SHIFT  = 9,
  parameter int IDX_W  = 2,
  localparam int LO_W  = WORD_W - 1 - SHIFT,
  localparam int UL_W  = WORD_W - SHIFT,
  localparam int HI_W  = WORD_W - 1,
  localparam int TW    = UL_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_widx,
  input  logic              user_mode,
  input  logic [TW-1:0]     ticks,
  input  logic [LO_W-1:0]   lim,
  input  logic              reached,
  input  logic              running,
  output logic [WORD_W-1:0] rdata
);
  import tmr_pkg::*;
  logic [WORD_W-1:0] sel;

  always_comb begin
    sel = '0;
    case (bus_widx)
      IDX_W'(IDX_LIMIT):
        sel = user_mode ? {reached, ticks[TW-1:UL_W]} : {1'b0, lim, {SHIFT{1'b0}}};
      IDX_W'(IDX_COUNT):
        sel = user_mode ? {ticks[UL_W-1:0], {SHIFT{1'b0}}}
                        : {reached, ticks[LO_W-1:0], {SHIFT{1'b0}}};
      IDX_W'(IDX_STAT):
        sel = {{(WORD_W-1){1'b0}}, running};
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_rd) rdata <= sel;
  end

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_widx == IDX_W'(IDX_COUNT)) |=> rdata[SHIFT-1:0] == '0); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata)); // R2
endmodule

// File: rtl/proc_timer.sv
module proc_timer #(
  parameter int WORD_W = 32,
  parameter int SHIFT  = 9,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int LO_W  = WORD_W - 1 - SHIFT,
  localparam int TW    = 2 * WORD_W - 1 - SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_widx,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              user_mode,
  input  logic              tick,
  output logic              irq
);
  import tmr_pkg::*;
  logic [NREG-1:0] wr_vec;
  logic            rd_lim;
  logic [TW-1:0]   ticks;
  logic [LO_W-1:0] lim;
  logic            reached, running;

  tmr_decode #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_widx(bus_widx),
    .user_mode(user_mode), .wr_vec(wr_vec), .rd_lim(rd_lim)
  );

  tmr_core #(.WORD_W(WORD_W), .SHIFT(SHIFT)) u_core (
    .clk(clk), .rst(rst), .user_mode(user_mode), .tick(tick),
    .wr_lim(wr_vec[IDX_LIMIT]), .wr_cnt(wr_vec[IDX_COUNT]),
    .wr_nrs(wr_vec[IDX_LIMNR]), .wr_sts(wr_vec[IDX_STAT]),
    .rd_lim(rd_lim), .wdata(bus_wdata),
    .ticks_o(ticks), .lim_o(lim), .reached_o(reached),
    .running_o(running), .irq_o(irq)
  );

  tmr_rdmux #(.WORD_W(WORD_W), .SHIFT(SHIFT), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_widx(bus_widx),
    .user_mode(user_mode), .ticks(ticks), .lim(lim), .reached(reached),
    .running(running), .rdata(bus_rdata)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec)); // R2
endmodule

// File: tb/sim_proc_timer.sv
`timescale 1ns/1ps
module sim_proc_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, user_mode = 1'b0, tick = 1'b0;
  logic [1:0]  bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  proc_timer u0 (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .user_mode(user_mode),
    .tick(tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_widx = idx;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_widx = idx; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3, d); chk("R1 status", d, 32'd1);
    rd(1, d); chk("R1 count", d, 32'd0);
    rd(0, d); chk("R1 limit", d, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    // R3 free-running steps of 512
    tk(5);
    rd(1, d); chk("R3 free count", d, 32'h0000_0A00);
    chk("R4 free no irq", {31'b0, irq}, 32'd0);
    // R4/R5/R6 sweep over limits
    for (int L = 1; L <= 6; L++) begin
      wr(0, 32'(L * 512) | 32'h8000_01FF);
      rd(1, d); chk("R5 restart", d, 32'd0);
      for (int k = 1; k < L; k++) begin
        tk(1);
        rd(1, d); chk("R3 sweep count", d, 32'(k * 512));
        chk("R4 irq low", {31'b0, irq}, 32'd0);
      end
      tk(1);
      chk("R4 irq high", {31'b0, irq}, 32'd1);
      rd(1, d); chk("R4 reached count", d, 32'h8000_0000 | 32'(L * 512));
      tk(1);
      rd(1, d); chk("R4 wrap", d, 32'h8000_0000);
      rd(0, d); chk("R6 limit read", d, 32'(L * 512));
      chk("R6 irq cleared", {31'b0, irq}, 32'd0);
      rd(1, d); chk("R6 flag cleared", d, 32'd0);
    end
    // R5 limit-without-restart
    wr(0, 32'h0000_2000);
    tk(3);
    wr(2, 32'h0000_0400);
    rd(1, d); chk("R5 norst count kept", d, 32'h0000_0600);
    // R7 counter write ignored
    wr(1, 32'h1234_5600);
    rd(1, d); chk("R7 count write ignored", d, 32'h0000_0600);
    // R2 index 2 reads zero
    rd(2, d); chk("R2 index2", d, 32'd0);
    rd(0, d); chk("R2 limit index", d, 32'h0000_0400);
    // arm irq then enter user mode
    wr(0, 32'h0000_0200);
    tk(1);
    chk("R4 one-step limit", {31'b0, irq}, 32'd1);
    @(negedge clk); user_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 irq dropped", {31'b0, irq}, 32'd0);
    rd(3, d); chk("R11 stopped", d, 32'd0);
    rd(0, d); chk("R11 msw zero", d, 32'd0);
    rd(1, d); chk("R11 lsw zero", d, 32'd0);
    // R8 loads
    wr(1, 32'h0000_1234);
    wr(0, 32'h0000_0005);
    rd(1, d); chk("R8 lsw load", d, 32'h0000_1200);
    rd(0, d); chk("R8 msw load", d, 32'h0000_0005);
    // R9 stopped ignores ticks, then start/stop
    tk(3);
    rd(1, d); chk("R9 stopped hold", d, 32'h0000_1200);
    wr(3, 32'd1);
    rd(3, d); chk("R9 running", d, 32'd1);
    tk(4);
    rd(1, d); chk("R9 counting", d, 32'h0000_1A00);
    chk("R10 no irq", {31'b0, irq}, 32'd0);
    wr(3, 32'd0);
    rd(3, d); chk("R9 stopped", d, 32'd0);
    tk(2);
    rd(1, d); chk("R9 stop hold", d, 32'h0000_1A00);
    // R8 carry into high half
    wr(1, 32'hFFFF_FE00);
    wr(0, 32'd0);
    wr(3, 32'd1);
    tk(1);
    rd(1, d); chk("R8 carry lsw", d, 32'd0);
    rd(0, d); chk("R8 carry msw", d, 32'd1);
    // R10 maximum and wrap
    wr(0, 32'h7FFF_FFFF);
    wr(1, 32'hFFFF_FC00);
    tk(1);
    rd(0, d); chk("R10 max reached", d, 32'hFFFF_FFFF);
    chk("R10 irq stays low", {31'b0, irq}, 32'd0);
    tk(1);
    rd(0, d); chk("R10 wrap msw", d, 32'h8000_0000);
    rd(1, d); chk("R10 wrap lsw", d, 32'd0);
    wr(1, 32'd0);
    rd(0, d); chk("R8 write clears flag", d, 32'd0);
    // R11 return to counter mode
    @(negedge clk); user_mode = 1'b0;
    repeat (2) @(negedge clk);
    rd(3, d); chk("R11 running again", d, 32'd1);
    rd(1, d); chk("R11 count cleared", d, 32'd0);
    rd(0, d); chk("R11 limit kept", d, 32'h0000_0200);
    tk(1);
    chk("R11 irq after return", {31'b0, irq}, 32'd1);
    rd(1, d); chk("R11 reached after return", d, 32'h8000_0200);
    finish_run();
  end
endmodule